// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of external interrupt requests and distributes them to a set of targets. A target is one privilege level of one hardware thread. Each source has a programmable priority and each target has a programmable threshold. Each target also keeps its own enable bit for every source. The block drives one registered interrupt line per target. A target asks which source to service by reading its claim register. The read hands back the best eligible source and removes that source from the pending set. The target later writes the same source number back to mark the work finished.

Each source passes through a gateway. A parameter chooses, per source, whether the gateway captures rising edges or sampled levels. Once the gateway has captured a request, the targets cannot tell which kind of gateway captured it. A claimed source is held back until its completion arrives. An edge that arrives during that time is remembered and delivered after the completion. A level source is pending again after completion only while its input is still high.

Configuration and the claim/complete handshake use one flat register port. A 2-bit selector picks the register kind and an index picks the source or target. Source number 0 is reserved and means "nothing to service". The number of targets must not exceed the number of sources.

Top module: `plic_core`

## Requirements
- R1: A source whose enable bit for a target is 0 never raises that target's line and is never returned by that target's claim. Enables for other targets are unaffected.
- R2: A claim returns the eligible source with the highest priority. When priorities are equal, the lowest source number wins.
- R3: A source is eligible for a target only when its priority is greater than or equal to the target's threshold. A priority equal to the threshold is eligible.
- R4: A source with priority 0 is never eligible. A claim with nothing eligible returns 0.
- R5: A claim read clears that source's pending state. The source is not delivered again until a completion write for that target carries its number. A completion carrying any other number has no effect on it.
- R6: For an edge source, several rising edges while pending merge into one request. A rising edge that arrives while the source is claimed becomes pending when the completion is written.
- R7: For a level source, the completion makes the source pending again only if its input is high. A low input leaves it idle.
- R8: A target's line is registered. After a write that makes a source eligible, the line rises on the second clock edge counted from the edge that takes the write.
- R9: Selector codes: 0 = priority (index = source 1..NSRC, low PRIO_W data bits). 1 = enable (index = target; data bit s is source s; bit 0 reads 0). 2 = threshold (index = target). 3 = claim on read, completion on write (index = target). Written values read back.
- R10: After reset, all priorities, enables and thresholds are 0, all lines are low, and every claim returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Interrupt inputs; bit s-1 is source s |
| reg_rd | input | 1 | Read strobe; a read of selector 3 claims |
| reg_wr | input | 1 | Write strobe; a write of selector 3 completes |
| reg_sel | input | 2 | Register kind (see R9) |
| reg_idx | input | IDX_W | Source or target index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from selector and index |
| irq | output | NTGT | Registered interrupt line per target |

## Verification
The main tests use level sources held high with different priorities. Two sources share the top priority, which separates the tie rule from plain priority order. A threshold equal to one priority and above another shows where the threshold comparison cuts off. Repeated short pulses on an edge source, with pulses placed before and during its claim, separate merging from remembering. A level input that is dropped or kept high across completion separates re-arming from idle. Wrong-number completions and claims on a target with the source disabled show that the state changes neither.

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC   = 8,
  parameter int NTGT   = 2,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter logic [NSRC:1] EDGE_SRC = 8'hF0,
  localparam int IDW   = $clog2(NSRC + 1),
  localparam int IDX_W = IDW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NTGT-1:0]   irq
);
  localparam int TW = (NTGT > 1) ? $clog2(NTGT) : 1;
  localparam logic [1:0] SEL_PRIO = 2'd0, SEL_EN = 2'd1, SEL_THR = 2'd2, SEL_CC = 2'd3;

  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [NTGT-1:0][NSRC:1]   en_q;
  logic [NTGT-1:0][PRIO_W-1:0] thr_q;
  logic [NSRC:1] pend_q, clmd_q, seen_q, src_q, rise;
  logic [NTGT-1:0][IDW-1:0]    best_id;
  logic [NTGT-1:0][PRIO_W-1:0] best_pr;

  wire           tgt_ok   = reg_idx < IDX_W'(NTGT);
  wire           src_ok   = (reg_idx != '0) && (reg_idx <= IDX_W'(NSRC));
  wire [TW-1:0]  tsel     = tgt_ok ? TW'(reg_idx) : '0;
  wire [IDW-1:0] claim_id = best_id[tsel];
  wire           claim_go = reg_rd && reg_sel == SEL_CC && tgt_ok;
  wire           comp_go  = reg_wr && reg_sel == SEL_CC && tgt_ok;
  wire [IDW-1:0] comp_id  = reg_wdata[IDW-1:0];

  for (genvar g = 1; g <= NSRC; g++) begin : g_gw
    if (EDGE_SRC[g]) begin : g_edge
      assign rise[g] = src_in[g-1] & ~src_q[g];
    end else begin : g_level
      assign rise[g] = src_in[g-1];
    end
  end

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      best_id[t] = '0;
      best_pr[t] = '0;
      for (int i = NSRC; i >= 1; i--) begin
        if (pend_q[i] && en_q[t][i] && prio_q[i] != '0 &&
            prio_q[i] >= thr_q[t] && prio_q[i] >= best_pr[t]) begin
          best_pr[t] = prio_q[i];
          best_id[t] = IDW'(i);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_PRIO: if (src_ok) reg_rdata[PRIO_W-1:0] = prio_q[reg_idx];
      SEL_EN:   if (tgt_ok) reg_rdata[NSRC:1] = en_q[tsel];
      SEL_THR:  if (tgt_ok) reg_rdata[PRIO_W-1:0] = thr_q[tsel];
      default:  if (tgt_ok) reg_rdata[IDW-1:0] = claim_id;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_PRIO && src_ok) prio_q[reg_idx] <= reg_wdata[PRIO_W-1:0];
      if (reg_sel == SEL_EN && tgt_ok)   en_q[tsel] <= reg_wdata[NSRC:1];
      if (reg_sel == SEL_THR && tgt_ok)  thr_q[tsel] <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      clmd_q <= '0;
      seen_q <= '0;
      src_q  <= '0;
    end else begin
      src_q <= src_in;
      for (int i = 1; i <= NSRC; i++) begin
        if (claim_go && claim_id == IDW'(i)) begin
          pend_q[i] <= 1'b0;
          clmd_q[i] <= 1'b1;
        end else if (clmd_q[i]) begin
          if (comp_go && comp_id == IDW'(i)) begin
            clmd_q[i] <= 1'b0;
            pend_q[i] <= seen_q[i] | rise[i];
            seen_q[i] <= 1'b0;
          end else if (EDGE_SRC[i] && rise[i]) begin
            seen_q[i] <= 1'b1;
          end
        end else if (rise[i]) begin
          pend_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else for (int t = 0; t < NTGT; t++) irq[t] <= best_id[t] != '0;
  end
endmodule

module plic_core_chk #(
  parameter int NSRC = 8,
  parameter int NTGT = 2,
  parameter int IDW  = 4,
  parameter int IDX_W = 4,
  parameter int DATA_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic reg_rd,
  input logic [1:0] reg_sel,
  input logic [IDX_W-1:0] reg_idx,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NTGT-1:0] irq,
  input logic [NSRC:1] pend,
  input logic [NSRC:1] clmd,
  input logic [NTGT-1:0][NSRC:1] en
);
  logic [IDW-1:0] last_id;
  wire  [NSRC:0]  clmd_ext = {clmd, 1'b0};
  wire claim_rd = reg_rd && reg_sel == 2'd3 && reg_idx < IDX_W'(NTGT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_id <= '0;
    else last_id <= reg_rdata[IDW-1:0];

  AST_PEND_OR_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n) (pend & clmd) == '0); // R5
  AST_CLAIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) claim_rd |-> reg_rdata <= DATA_W'(NSRC)); // R4
  AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (claim_rd && reg_rdata != '0) |=> clmd_ext[last_id]); // R5

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (en[t] == '0) |=> !irq[t]); // R1
  end
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NTGT(NTGT), .IDW(IDW), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_idx(reg_idx),
  .reg_rdata(reg_rdata), .irq(irq), .pend(pend_q), .clmd(clmd_q), .en(en_q)
);

// File: tb/test_plic_core.sv
module test_plic_core;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] src_in = '0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_sel = '0;
  logic [3:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0] irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  plic_core #(.NSRC(8), .NTGT(2), .PRIO_W(3), .DATA_W(32), .EDGE_SRC(8'hF0)) i_plic_core (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = s; reg_idx = idx[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_sel = s; reg_idx = idx[3:0];
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic expect_claim(input int tgt, input int exp, input string tag);
    logic [31:0] d;
    rd(2'd3, tgt, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_in[s-1] = 1;
    @(negedge clk); src_in[s-1] = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; src_in = '0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    chk(irq == 2'b00, "R10 lines low", irq, 0);
    expect_claim(0, 0, "R10 claim t0");
    expect_claim(1, 0, "R10 claim t1");
    rd(2'd0, 3, d);
    chk(d == 0, "R10 prio reset", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    do_reset();
    wr(2'd0, 3, 5);     rd(2'd0, 3, d); chk(d == 5, "R9 prio readback", d, 5);
    wr(2'd0, 3, 'hF);   rd(2'd0, 3, d); chk(d == 7, "R9 prio width", d, 7);
    wr(2'd1, 1, 'h0A);  rd(2'd1, 1, d); chk(d == 'h0A, "R9 enable readback", d, 'h0A);
    wr(2'd1, 0, 'h1FF); rd(2'd1, 0, d); chk(d == 'h1FE, "R9 enable bit0", d, 'h1FE);
    wr(2'd2, 0, 4);     rd(2'd2, 0, d); chk(d == 4, "R9 threshold readback", d, 4);
  endtask

  task automatic t_enable_level;
    do_reset();
    wr(2'd0, 2, 3);
    @(negedge clk); src_in[1] = 1;
    idle(3);
    chk(irq[0] == 0, "R1 not enabled", irq[0], 0);
    wr(2'd1, 0, 32'h4);
    chk(irq[0] == 0, "R8 line not yet", irq[0], 0);
    idle(1);
    chk(irq[0] == 1, "R8 line after two edges", irq[0], 1);
    chk(irq[1] == 0, "R1 other target quiet", irq[1], 0);
    expect_claim(1, 0, "R1 claim disabled target");
    expect_claim(0, 2, "R5 claim returns id");
    idle(1);
    chk(irq[0] == 0, "R5 line drops after claim", irq[0], 0);
    expect_claim(0, 0, "R5 no redelivery");
    wr(2'd3, 0, 3);
    idle(2);
    expect_claim(0, 0, "R5 wrong completion ignored");
    wr(2'd3, 0, 2);
    idle(1);
    expect_claim(0, 2, "R7 level high rearms");
    @(negedge clk); src_in[1] = 0;
    wr(2'd3, 0, 2);
    idle(2);
    expect_claim(0, 0, "R7 level low stays idle");
    chk(irq[0] == 0, "R7 line low", irq[0], 0);
  endtask

  task automatic t_priority;
    do_reset();
    wr(2'd0, 1, 2); wr(2'd0, 3, 6); wr(2'd0, 4, 6);
    wr(2'd1, 0, 32'h1FE);
    @(negedge clk); src_in[3:0] = 4'b1111;
    idle(3);
    expect_claim(0, 3, "R2 tie lowest id");
    expect_claim(0, 4, "R2 next equal priority");
    expect_claim(0, 1, "R2 lower priority last");
    expect_claim(0, 0, "R4 priority zero never");
    wr(2'd3, 0, 1); wr(2'd3, 0, 3); wr(2'd3, 0, 4);
    wr(2'd2, 0, 6);
    idle(2);
    expect_claim(0, 3, "R3 equal threshold eligible");
    expect_claim(0, 4, "R3 second at threshold");
    expect_claim(0, 0, "R3 below threshold blocked");
    idle(2);
    chk(irq[0] == 0, "R3 line low below threshold", irq[0], 0);
  endtask

  task automatic t_edge;
    do_reset();
    wr(2'd0, 5, 1);
    wr(2'd1, 1, 32'h20);
    pulse(5); pulse(5); pulse(5);
    idle(2);
    chk(irq[1] == 1, "R6 edge raises line", irq[1], 1);
    expect_claim(1, 5, "R6 edge claim");
    expect_claim(1, 0, "R6 edges merged");
    pulse(5);
    expect_claim(1, 0, "R6 held while claimed");
    wr(2'd3, 1, 5);
    idle(1);
    expect_claim(1, 5, "R6 remembered edge");
    wr(2'd3, 1, 5);
    idle(2);
    expect_claim(1, 0, "R6 no extra request");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_enable_level();
    t_priority();
    t_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule